// File: doc/BRIEF.md
# Transmit Symbol-Pair Injection Controller

This block produces the 10-bit symbol pair handed to a serial line transmitter, one pair on every symbol-pair clock. In normal operation it forwards the incoming request pair. A 3-bit transmit mode can replace that stream with fixed line-state pairs (Idle, Halt, Quiet, or a Halt/Quiet mix), or switch the line off, which sends Quiet and drops the transmitter enable.

Above the mode sits a programmable injection stage. It replaces the pair with two stored 5-bit symbols. Injection can happen once at a counted distance after a JK start, periodically, or on every pair. An 8-bit reloading down-counter, loaded from a threshold register, sets the timing. After a one-shot injection the block clears the injection control field by itself, and software reads that as the acknowledgment.

Software drives a simple write port with one register per address. Control state and the live counter value are visible on output ports. Outputs are registered: the pair presented with the inputs at one rising edge appears after that edge. The same holds for the transmit enable.

Top module: `txi_top`

## Requirements
- R1: After reset, ctl_state reads 8'hA2 (mode field bits 2:0 = 010, bit 5 = 1, bit 7 = 1, all else 0), inj_count is 0, pair_out is 0 and tx_en is 0.
- R2: The pair is output one clock after it is sampled. A register write at an edge takes effect from the next pair onward, so the pair sampled with the write still uses the old settings.
- R3: Mode field ctl_state[2:0]: 000 forwards pair_in, 001 sends 10'h3FF, 100 sends 10'h080, 101 sends 10'h084, and 110 sends 10'h000. The first symbol is in pair bits 9:5.
- R4: Mode 010 sends 10'h000 with tx_en low. Codes 011 and 111 send 10'h000 with tx_en high, and every code other than 010 drives tx_en high.
- R5: An injected pair is {symbol A[4:0], symbol B[4:0]} and overrides every transmit mode.
- R6: Injection field ctl_state[4:3] = 11 replaces every pair. With 00, no pair is replaced.
- R7: With field 10 and threshold n, every (n+1)th pair is replaced, counted from the counter value. With n = 0 every pair is replaced.
- R8: In periodic mode the counter steps down once per pair and reloads from the threshold at zero. A threshold write (address 1) loads the written value at once. With injection off the counter holds. inj_count shows it.
- R9: With field 01 and threshold n, the pair n pairs after the next JK (jk_in high) is replaced. With n = 0 the JK pair itself is replaced. The counter holds until a JK arrives.
- R10: After a one-shot injection, bit 3 of ctl_state clears by itself, and later JKs cause no injection.
- R11: A JK seen while a one-shot count is running restarts the count from the threshold.
- R12: Symbol registers (address 2 for A, 3 for B) use only data bits 4:0. Bits 7:5 of the written byte have no effect. Address 0 is the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-pair clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_in | input | 10 | Incoming request symbol pair |
| jk_in | input | 1 | Marks pair_in as a JK start pair |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| pair_out | output | 10 | Transmitted symbol pair |
| tx_en | output | 1 | Transmitter enable |
| inj_count | output | 8 | Current injection counter value |
| ctl_state | output | 8 | Current control register contents |

## Verification
The assertions assume that pair_in, jk_in and the write port are settled before each rising edge and change at most once per pair. They also assume at most one register write per pair and that reset is held across at least one edge before the first pair. The stimulus changes inputs only at falling edges and issues writes as single-pair operations on top of the data stream. It walks through every mode code, all four injection settings, JK restarts and zero thresholds, always starting from the reset state.

// File: rtl/txi_pkg.sv
package txi_pkg;
  localparam int SYM_W  = 5;
  localparam int PAIR_W = 2 * SYM_W;

  // control register field positions
  localparam int MODE_LSB = 0;
  localparam int INJ_LSB  = 3;
  localparam int INJ_ONCE_BIT = INJ_LSB;

  // register addresses
  localparam int A_CTL  = 0;
  localparam int A_THR  = 1;
  localparam int A_SYMA = 2;
  localparam int A_SYMB = 3;

  localparam logic [7:0] CTL_RESET = 8'hA2;

  localparam logic [SYM_W-1:0] SYM_QUIET = '0;
  localparam logic [SYM_W-1:0] SYM_IDLE  = '1;
  localparam logic [SYM_W-1:0] SYM_HALT  = 5'b00100;

  typedef enum logic [2:0] {
    TM_PASS   = 3'b000,
    TM_IDLE   = 3'b001,
    TM_OFF    = 3'b010,
    TM_RSV3   = 3'b011,
    TM_MASTER = 3'b100,
    TM_HALT   = 3'b101,
    TM_QUIET  = 3'b110,
    TM_RSV7   = 3'b111
  } tx_mode_e;

  typedef enum logic [1:0] {
    IJ_NONE     = 2'b00,
    IJ_ONCE     = 2'b01,
    IJ_PERIODIC = 2'b10,
    IJ_CONT     = 2'b11
  } inj_mode_e;
endpackage

// File: rtl/txi_ctlregs.sv
module txi_ctlregs
  import txi_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              once_done,
  output logic [REG_W-1:0]  ctl_q,
  output logic [CNT_W-1:0]  thr_q,
  output logic              thr_wr,
  output logic [SYM_W-1:0]  sym_a,
  output logic [SYM_W-1:0]  sym_b
);
  localparam int NSYM = 2;

  logic [SYM_W-1:0] sym_q [NSYM];
  logic             ctl_wr;

  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTL));
  assign thr_wr = bus_wr && (bus_addr == ADDR_W'(A_THR));

  // control register: a software write wins over the one-shot auto-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= REG_W'(CTL_RESET);
    end else if (ctl_wr) begin
      ctl_q <= bus_wdata;
    end else if (once_done) begin
      ctl_q[INJ_ONCE_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q <= '0;
    end else if (thr_wr) begin
      thr_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // two symbol registers at consecutive addresses; only the symbol bits are kept
  for (genvar g = 0; g < NSYM; g++) begin : g_sym
    always_ff @(posedge clk) begin
      if (rst) begin
        sym_q[g] <= '0;
      end else if (bus_wr && (bus_addr == ADDR_W'(A_SYMA + g))) begin
        sym_q[g] <= bus_wdata[SYM_W-1:0];
      end
    end
  end

  assign sym_a = sym_q[0];
  assign sym_b = sym_q[1];
endmodule

// File: rtl/txi_inj_counter.sv
module txi_inj_counter
  import txi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       inj_mode,
  input  logic [CNT_W-1:0] thr_q,
  input  logic             thr_wr,
  input  logic [CNT_W-1:0] thr_new,
  input  logic             jk,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inject,
  output logic             once_done
);
  logic             run_q;
  logic             active;
  logic [CNT_W-1:0] eff;

  // eff is the count that applies to the current pair; a JK in one-shot
  // mode substitutes the threshold so that a zero threshold hits the JK itself
  always_comb begin
    active = 1'b0;
    eff    = cnt_q;
    case (inj_mode_e'(inj_mode))
      IJ_PERIODIC: active = 1'b1;
      IJ_ONCE: begin
        if (jk) begin
          active = 1'b1;
          eff    = thr_q;
        end else begin
          active = run_q;
        end
      end
      default: active = 1'b0;
    endcase
    inject    = (inj_mode_e'(inj_mode) == IJ_CONT) || (active && (eff == '0));
    once_done = (inj_mode_e'(inj_mode) == IJ_ONCE) && inject;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (thr_wr) begin
        cnt_q <= thr_new;
      end else if (active) begin
        cnt_q <= (eff == '0) ? thr_q : eff - CNT_W'(1);
      end
      run_q <= (inj_mode_e'(inj_mode) == IJ_ONCE) && (jk || run_q) && !inject;
    end
  end
endmodule

// File: rtl/txi_out_stage.sv
module txi_out_stage
  import txi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic              inject,
  input  logic [PAIR_W-1:0] pair_in,
  input  logic [SYM_W-1:0]  sym_a,
  input  logic [SYM_W-1:0]  sym_b,
  output logic [PAIR_W-1:0] pair_q,
  output logic              en_q
);
  logic [PAIR_W-1:0] mode_pair;

  always_comb begin
    case (tx_mode_e'(mode))
      TM_PASS:   mode_pair = pair_in;
      TM_IDLE:   mode_pair = {SYM_IDLE, SYM_IDLE};
      TM_MASTER: mode_pair = {SYM_HALT, SYM_QUIET};
      TM_HALT:   mode_pair = {SYM_HALT, SYM_HALT};
      default:   mode_pair = {SYM_QUIET, SYM_QUIET};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= {SYM_QUIET, SYM_QUIET};
      en_q   <= 1'b0;
    end else begin
      pair_q <= inject ? {sym_a, sym_b} : mode_pair;
      en_q   <= (tx_mode_e'(mode) != TM_OFF);
    end
  end
endmodule

// File: rtl/txi_top.sv
module txi_top
  import txi_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAIR_W-1:0] pair_in,
  input  logic              jk_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [PAIR_W-1:0] pair_out,
  output logic              tx_en,
  output logic [CNT_W-1:0]  inj_count,
  output logic [REG_W-1:0]  ctl_state
);
  logic [REG_W-1:0] ctl_q;
  logic [CNT_W-1:0] thr_q;
  logic             thr_wr;
  logic [SYM_W-1:0] sym_a;
  logic [SYM_W-1:0] sym_b;
  logic [CNT_W-1:0] cnt_q;
  logic             inject;
  logic             once_done;

  txi_ctlregs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .once_done(once_done),
    .ctl_q    (ctl_q),
    .thr_q    (thr_q),
    .thr_wr   (thr_wr),
    .sym_a    (sym_a),
    .sym_b    (sym_b)
  );

  txi_inj_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .inj_mode (ctl_q[INJ_LSB +: 2]),
    .thr_q    (thr_q),
    .thr_wr   (thr_wr),
    .thr_new  (bus_wdata[CNT_W-1:0]),
    .jk       (jk_in),
    .cnt_q    (cnt_q),
    .inject   (inject),
    .once_done(once_done)
  );

  txi_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .mode   (ctl_q[MODE_LSB +: 3]),
    .inject (inject),
    .pair_in(pair_in),
    .sym_a  (sym_a),
    .sym_b  (sym_b),
    .pair_q (pair_out),
    .en_q   (tx_en)
  );

  assign inj_count = cnt_q;
  assign ctl_state = ctl_q;
endmodule

// File: rtl/txi_chk.sv
module txi_chk
  import txi_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  thr_new,
  input logic [2:0]        mode,
  input logic [1:0]        inj,
  input logic [CNT_W-1:0]  thr_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [SYM_W-1:0]  sym_a,
  input logic [SYM_W-1:0]  sym_b,
  input logic              inject,
  input logic [PAIR_W-1:0] pair_out,
  input logic              tx_en
);
  logic ctl_wr;
  logic thr_wr;
  assign ctl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTL));
  assign thr_wr = bus_wr && (bus_addr == ADDR_W'(A_THR));

  // R4
  off_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b010) |=> !tx_en);

  // R4
  on_enables_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'b010) |=> tx_en);

  // R5
  inject_pair_chk: assert property (@(posedge clk) disable iff (rst)
    inject |=> (pair_out == $past({sym_a, sym_b})));

  // R6
  cont_always_chk: assert property (@(posedge clk) disable iff (rst)
    (inj == 2'b11) |-> inject);

  // R6
  none_never_chk: assert property (@(posedge clk) disable iff (rst)
    (inj == 2'b00) |-> !inject);

  // R8
  thr_load_chk: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> (cnt_q == $past(thr_new)));

  // R8
  periodic_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!thr_wr && inj == 2'b10) |=>
      (cnt_q == (($past(cnt_q) == '0) ? $past(thr_q) : $past(cnt_q) - CNT_W'(1))));

  // R10
  once_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_wr && inj == 2'b01 && inject) |=> (inj == 2'b00));
endmodule

bind txi_top txi_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .thr_new (bus_wdata[CNT_W-1:0]),
  .mode    (ctl_q[2:0]),
  .inj     (ctl_q[4:3]),
  .thr_q   (thr_q),
  .cnt_q   (cnt_q),
  .sym_a   (sym_a),
  .sym_b   (sym_b),
  .inject  (inject),
  .pair_out(pair_out),
  .tx_en   (tx_en)
);

// File: tb/txi_top_test.sv
module txi_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] pair_in = '0;
  logic       jk_in = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [9:0] pair_out;
  logic       tx_en;
  logic [7:0] inj_count;
  logic [7:0] ctl_state;

  localparam logic [9:0] INJ = 10'h0BA;

  typedef struct {
    logic [9:0] p;
    logic       en;
    int         cnt;
    int         ctl;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   misses  = 0;
  bit   done    = 0;

  always #4 clk = ~clk;

  txi_top uut (
    .clk(clk), .rst(rst), .pair_in(pair_in), .jk_in(jk_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pair_out(pair_out), .tx_en(tx_en), .inj_count(inj_count), .ctl_state(ctl_state)
  );

  // monitor: compares the result of the pair consumed at the previous edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      vectors++;
      if (pair_out !== e.p || tx_en !== e.en ||
          (e.cnt >= 0 && int'(inj_count) != e.cnt) ||
          (e.ctl >= 0 && int'(ctl_state) != e.ctl)) begin
        misses++;
        $display("FAIL %s: pair %h en %b cnt %0d ctl %h, expected pair %h en %b cnt %0d ctl %0h",
                 e.tag, pair_out, tx_en, inj_count, ctl_state, e.p, e.en, e.cnt, e.ctl);
      end
    end
  end

  task automatic drive(input logic [9:0] d, input logic jk, input logic w,
                       input logic [1:0] a, input logic [7:0] wd,
                       input logic [9:0] ep, input logic een,
                       input int ecnt, input int ectl, input string tag);
    exp_t e;
    @(negedge clk);
    pair_in = d; jk_in = jk; bus_wr = w; bus_addr = a; bus_wdata = wd;
    e.p = ep; e.en = een; e.cnt = ecnt; e.ctl = ectl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pr(input logic [9:0] d, input logic jk, input logic [9:0] ep,
                    input logic een, input int ecnt, input int ectl, input string tag);
    drive(d, jk, 1'b0, 2'd0, 8'h00, ep, een, ecnt, ectl, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] wd, input logic [9:0] d,
                    input logic [9:0] ep, input logic een, input int ecnt,
                    input int ectl, input string tag);
    drive(d, 1'b0, 1'b1, a, wd, ep, een, ecnt, ectl, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    vectors++;
    if (ctl_state !== 8'hA2 || inj_count !== 8'h00 || pair_out !== 10'h000 || tx_en !== 1'b0) begin
      misses++;
      $display("FAIL R1: ctl %h cnt %h pair %h en %b, expected a2 00 000 0",
               ctl_state, inj_count, pair_out, tx_en);
    end
    @(negedge clk) rst = 1'b0;

    pr(10'h155, 0, 10'h000, 0, 0, 'hA2, "R1 off after reset");
    wr(0, 8'h20, 10'h155, 10'h000, 0, 0, 'h20, "R2 write pair keeps old mode");
    pr(10'h155, 0, 10'h155, 1, 0, 'h20, "R3 pass");
    pr(10'h2A3, 0, 10'h2A3, 1, 0, -1, "R3 pass second pattern");
    wr(0, 8'h21, 10'h111, 10'h111, 1, -1, 'h21, "R2 write pair keeps pass");
    pr(10'h111, 0, 10'h3FF, 1, -1, -1, "R3 idle");
    wr(0, 8'h24, 10'h111, 10'h3FF, 1, -1, -1, "R2 idle before master");
    pr(10'h111, 0, 10'h080, 1, -1, -1, "R3 master");
    wr(0, 8'h25, 10'h111, 10'h080, 1, -1, -1, "R2 master before halt");
    pr(10'h111, 0, 10'h084, 1, -1, -1, "R3 halt");
    wr(0, 8'h26, 10'h111, 10'h084, 1, -1, -1, "R2 halt before quiet");
    pr(10'h111, 0, 10'h000, 1, -1, -1, "R3 quiet");
    wr(0, 8'h23, 10'h111, 10'h000, 1, -1, -1, "R4 quiet before 011");
    pr(10'h111, 0, 10'h000, 1, -1, -1, "R4 reserved 011");
    wr(0, 8'h27, 10'h111, 10'h000, 1, -1, -1, "R4 before 111");
    pr(10'h111, 0, 10'h000, 1, -1, -1, "R4 reserved 111");
    wr(0, 8'h22, 10'h111, 10'h000, 1, -1, -1, "R4 before off");
    pr(10'h3C3, 0, 10'h000, 0, 0, 'h22, "R4 off");

    wr(2, 8'hE5, 10'h3C3, 10'h000, 0, -1, -1, "R12 write A");
    wr(3, 8'h1A, 10'h3C3, 10'h000, 0, -1, -1, "R12 write B");
    wr(0, 8'h3D, 10'h2F0, 10'h000, 0, -1, 'h3D, "R4 off before continuous");
    pr(10'h2F0, 0, INJ, 1, 0, -1, "R5 injection over halt");
    pr(10'h1F0, 0, INJ, 1, 0, -1, "R6 continuous");
    wr(2, 8'h05, 10'h1F0, INJ, 1, -1, -1, "R6 continuous during write");
    pr(10'h1F0, 0, INJ, 1, -1, -1, "R12 upper bits ignored");
    wr(0, 8'h38, 10'h321, INJ, 1, -1, 'h38, "R6 continuous before pass");
    pr(10'h321, 0, INJ, 1, 0, -1, "R6 continuous over pass");
    wr(0, 8'h20, 10'h321, INJ, 1, 0, 'h20, "R6 last continuous pair");
    pr(10'h321, 0, 10'h321, 1, 0, -1, "R6 no injection");

    wr(1, 8'h02, 10'h100, 10'h100, 1, 2, -1, "R8 threshold write loads counter");
    wr(0, 8'h30, 10'h101, 10'h101, 1, 2, 'h30, "R8 counter holds without injection");
    pr(10'h102, 0, 10'h102, 1, 1, -1, "R7 periodic first");
    pr(10'h103, 0, 10'h103, 1, 0, -1, "R7 periodic second");
    pr(10'h104, 0, INJ,     1, 2, -1, "R7 periodic third replaced");
    pr(10'h105, 0, 10'h105, 1, 1, -1, "R7 periodic");
    pr(10'h106, 0, 10'h106, 1, 0, -1, "R7 periodic");
    pr(10'h107, 0, INJ,     1, 2, -1, "R7 periodic sixth replaced");
    wr(1, 8'h00, 10'h108, 10'h108, 1, 0, -1, "R8 threshold write overrides step");
    pr(10'h109, 0, INJ, 1, 0, -1, "R7 zero threshold all replaced");
    pr(10'h10A, 0, INJ, 1, 0, -1, "R7 zero threshold all replaced");

    wr(0, 8'h20, 10'h10B, INJ, 1, 0, 'h20, "R7 last periodic pair");
    wr(1, 8'h03, 10'h10C, 10'h10C, 1, 3, -1, "R8 load 3");
    wr(0, 8'h28, 10'h10D, 10'h10D, 1, 3, 'h28, "R9 arm one-shot");
    pr(10'h10E, 0, 10'h10E, 1, 3, 'h28, "R9 counter holds before JK");
    pr(10'h10F, 0, 10'h10F, 1, 3, 'h28, "R9 counter holds before JK");
    pr(10'h110, 1, 10'h110, 1, 2, 'h28, "R9 JK starts count");
    pr(10'h111, 0, 10'h111, 1, 1, -1, "R9 counting");
    pr(10'h112, 0, 10'h112, 1, 0, -1, "R9 counting");
    pr(10'h113, 0, INJ,     1, 3, 'h20, "R9 third pair after JK replaced, R10 ack");
    pr(10'h114, 0, 10'h114, 1, 3, 'h20, "R10 no further injection");
    pr(10'h115, 1, 10'h115, 1, 3, 'h20, "R10 JK ignored after ack");

    wr(0, 8'h28, 10'h116, 10'h116, 1, 3, 'h28, "R11 rearm");
    pr(10'h117, 1, 10'h117, 1, 2, -1, "R11 first JK");
    pr(10'h118, 0, 10'h118, 1, 1, -1, "R11 counting");
    pr(10'h119, 1, 10'h119, 1, 2, -1, "R11 JK restarts count");
    pr(10'h11A, 0, 10'h11A, 1, 1, -1, "R11 counting");
    pr(10'h11B, 0, 10'h11B, 1, 0, -1, "R11 counting");
    pr(10'h11C, 0, INJ,     1, 3, 'h20, "R11 injection after restart");

    wr(1, 8'h00, 10'h11D, 10'h11D, 1, 0, -1, "R8 load zero");
    wr(0, 8'h28, 10'h11E, 10'h11E, 1, 0, 'h28, "R9 arm with zero threshold");
    pr(10'h11F, 0, 10'h11F, 1, 0, 'h28, "R9 no injection without JK");
    pr(10'h120, 1, INJ,     1, 0, 'h20, "R9 JK pair itself replaced");
    pr(10'h121, 0, 10'h121, 1, 0, 'h20, "R10 one-shot done");

    @(negedge clk);
    pair_in = '0; jk_in = 0; bus_wr = 0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule